// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block groups frame-completion events of one DMA channel into fewer interrupts. A down-counter is loaded with a threshold taken from the channel's control word. Each completed frame lowers it by one. When it reaches zero the block emits a one-cycle completion-flag set pulse and reloads the counter. A second mechanism handles a quiet link, so that a partial batch still gets reported. Every completion restarts a delay timer, also taken from the control word. If the timer runs out before the next completion, the block emits a delay-flag set pulse and reloads the counter.

The flag registers, interrupt masking and the register bus sit in a neighbouring block. That neighbour holds the control word, strobes `ctrl_wr` on every write to it, and reads `cnt_now` and `tmr_now` back into its status register. The timer advances on `tick`, a single-cycle enable that comes from a prescaler outside the block (by default it marks a 50 MHz reference).

The delay timer is a two-state machine, TMR_IDLE and TMR_RUN:
- TMR_IDLE to TMR_RUN happens on a completion with a nonzero delay field ("arm").
- TMR_RUN to TMR_RUN happens on a completion with a nonzero delay field ("re-arm", which reloads the count) and on a tick that leaves a nonzero count ("count").
- TMR_RUN to TMR_IDLE happens on a tick that takes the count to zero ("expire") and on soft reset ("abort").
- Both resets force TMR_IDLE.

Top module: `irq_coalesce`

## Requirements
- R1: After `rst_n` low, or in the cycle after `soft_rst` is high, `cnt_now` is 1, `tmr_now` is 0, the timer is stopped, and neither set pulse is high. `soft_rst` overrides every other input.
- R2: The threshold is `ctrl_word[23:16]` and the delay is `ctrl_word[31:24]`. A cycle with `ctrl_wr` high loads the counter from the threshold. A completion in that same cycle has no effect on the counter and raises no completion pulse.
- R3: Each `frame_done` cycle decrements the counter, modulo 256. When the result is zero, `ioc_set` is high for exactly the next cycle and the counter holds the threshold instead of zero.
- R4: A `frame_done` cycle with a nonzero delay field loads the timer with the delay and runs it, whether it was stopped or already running.
- R5: A `frame_done` cycle with a zero delay field leaves the timer's count and run state unchanged in that cycle, even if `tick` is high.
- R6: While the timer runs, each `tick` cycle without a completion lowers `tmr_now` by one. With no tick, no completion and no reset, `tmr_now` does not change.
- R7: A tick that takes the running timer to zero stops it at zero, makes `dly_set` high for exactly the next cycle, and reloads the counter from the threshold. Further ticks leave a stopped timer at zero.
- R8: If a completion and a timer expiry fall in the same cycle, the completion is handled as in R3 to R5 and no `dly_set` pulse is produced. As a result, `ioc_set` and `dly_set` are never high together.
- R9: All outputs are registered. They change only at the clock edge that ends the cycle in which the causing input was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous channel reset |
| ctrl_word | input | 32 | Live control word (threshold and delay fields) |
| ctrl_wr | input | 1 | One-cycle strobe for a control-word write |
| frame_done | input | 1 | One-cycle frame-completion event |
| tick | input | 1 | Prescaled timer enable |
| ioc_set | output | 1 | Completion-flag set pulse |
| dly_set | output | 1 | Delay-flag set pulse |
| cnt_now | output | 8 | Live completion counter |
| tmr_now | output | 8 | Live delay-timer count |

## Verification
The assertions assume that `ctrl_word` is the value the neighbour actually holds, so a threshold or delay sampled in a cycle is the one that governs that cycle. They also assume that `soft_rst` and `ctrl_wr` are single-cycle synchronous strobes. The stimulus changes `ctrl_word` only between cycles and keeps delays and thresholds small, so that expiry, wrap, reload and the same-cycle collisions all occur often. Directed sequences put a completion on the exact cycle the timer would expire, and put a write in the same cycle as a completion. A random phase then mixes all inputs.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/cmpl_counter.sv
module cmpl_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         load,
    input  logic         dec,
    input  logic         expire,
    input  logic [W-1:0] thresh,
    output logic         hit,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q, cnt_d, dec_val;

    assign dec_val = cnt_q - ONE;

    always_comb begin
        cnt_d = cnt_q;
        hit   = 1'b0;
        if (soft_rst) begin
            cnt_d = ONE;
        end else if (load) begin
            cnt_d = thresh;
        end else if (dec) begin
            if (dec_val == '0) begin
                cnt_d = thresh;
                hit   = 1'b1;
            end else begin
                cnt_d = dec_val;
            end
        end else if (expire) begin
            cnt_d = thresh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= ONE;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/dly_timer.sv
module dly_timer
    import coal_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         start,
    input  logic         hold,
    input  logic         tick,
    input  logic [W-1:0] dly_val,
    output logic         expire,
    output logic [W-1:0] tmr_val
);
    localparam logic [W-1:0] ONE = W'(1);

    tmr_state_e   state_q, state_d;
    logic [W-1:0] tmr_q, tmr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        expire  = 1'b0;
        if (soft_rst) begin
            state_d = TMR_IDLE;
            tmr_d   = '0;
        end else begin
            unique case (state_q)
                TMR_IDLE: begin
                    if (start) begin
                        state_d = TMR_RUN;
                        tmr_d   = dly_val;
                    end
                end
                TMR_RUN: begin
                    if (start) begin
                        tmr_d = dly_val;
                    end else if (!hold && tick) begin
                        if (tmr_q == ONE) begin
                            state_d = TMR_IDLE;
                            tmr_d   = '0;
                            expire  = 1'b1;
                        end else begin
                            tmr_d = tmr_q - ONE;
                        end
                    end
                end
                default: begin
                    state_d = TMR_IDLE;
                    tmr_d   = '0;
                end
            endcase
        end
    end

    assign tmr_val = tmr_q;
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
    parameter int CNT_W   = 8,
    parameter int TMR_W   = 8,
    parameter int THR_LSB = 16,
    localparam int DLY_LSB = THR_LSB + CNT_W,
    localparam int CTRL_W  = DLY_LSB + TMR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              ctrl_wr,
    input  logic              frame_done,
    input  logic              tick,
    output logic              ioc_set,
    output logic              dly_set,
    output logic [CNT_W-1:0]  cnt_now,
    output logic [TMR_W-1:0]  tmr_now
);
    logic [CNT_W-1:0] thresh;
    logic [TMR_W-1:0] dly_val;
    logic             start, hit, expire;
    logic             unused_low;

    assign thresh     = ctrl_word[THR_LSB +: CNT_W];
    assign dly_val    = ctrl_word[DLY_LSB +: TMR_W];
    assign unused_low = ^ctrl_word[THR_LSB-1:0];
    assign start      = frame_done && (dly_val != '0);

    dly_timer #(.W(TMR_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .start    (start),
        .hold     (frame_done),
        .tick     (tick),
        .dly_val  (dly_val),
        .expire   (expire),
        .tmr_val  (tmr_now)
    );

    cmpl_counter #(.W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .load     (ctrl_wr),
        .dec      (frame_done),
        .expire   (expire),
        .thresh   (thresh),
        .hit      (hit),
        .cnt      (cnt_now)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ioc_set <= 1'b0;
            dly_set <= 1'b0;
        end else begin
            ioc_set <= hit;
            dly_set <= expire;
        end
    end
endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk #(
    parameter int CNT_W   = 8,
    parameter int TMR_W   = 8,
    parameter int THR_LSB = 16,
    parameter int CTRL_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic              ctrl_wr,
    input logic              frame_done,
    input logic              tick,
    input logic              ioc_set,
    input logic              dly_set,
    input logic [CNT_W-1:0]  cnt_now,
    input logic [TMR_W-1:0]  tmr_now
);
    localparam int DLY_LSB = THR_LSB + CNT_W;

    assert_soft_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cnt_now == CNT_W'(1)) && (tmr_now == '0) && !ioc_set && !dly_set);

    assert_write_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !soft_rst) |=> (cnt_now == $past(ctrl_word[THR_LSB +: CNT_W])) && !ioc_set);

    assert_arm_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !soft_rst && (ctrl_word[DLY_LSB +: TMR_W] != '0))
        |=> (tmr_now == $past(ctrl_word[DLY_LSB +: TMR_W])));

    assert_timer_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !frame_done && !soft_rst) |=> $stable(tmr_now));

    assert_expire_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dly_set |-> (tmr_now == '0));

    assert_no_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ioc_set && dly_set));

    assert_ioc_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ioc_set |-> $past(frame_done) && !$past(ctrl_wr) && !$past(soft_rst));
endmodule

bind irq_coalesce irq_coalesce_chk #(
    .CNT_W(CNT_W), .TMR_W(TMR_W), .THR_LSB(THR_LSB), .CTRL_W(CTRL_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ctrl_word(ctrl_word),
    .ctrl_wr(ctrl_wr), .frame_done(frame_done), .tick(tick),
    .ioc_set(ioc_set), .dly_set(dly_set), .cnt_now(cnt_now), .tmr_now(tmr_now)
);

// File: tb/irq_coalesce_tb_top.sv
module irq_coalesce_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic        ctrl_wr = 1'b0;
    logic        frame_done = 1'b0;
    logic        tick = 1'b0;
    logic        ioc_set, dly_set;
    logic [7:0]  cnt_now, tmr_now;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int m_cnt = 1, m_tmr = 0;
    bit m_run = 0, m_ioc = 0, m_dly = 0;
    string cnt_tag = "R1", tmr_tag = "R1", dly_tag = "R7";

    always #2 clk = ~clk;

    irq_coalesce dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ctrl_word(ctrl_word),
        .ctrl_wr(ctrl_wr), .frame_done(frame_done), .tick(tick),
        .ioc_set(ioc_set), .dly_set(dly_set), .cnt_now(cnt_now), .tmr_now(tmr_now)
    );

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(cnt_tag, "cnt_now", int'(cnt_now), m_cnt);
        check(tmr_tag, "tmr_now", int'(tmr_now), m_tmr);
        check("R3", "ioc_set", int'(ioc_set), int'(m_ioc));
        check(dly_tag, "dly_set", int'(dly_set), int'(m_dly));
    endtask

    // behavioural reference step, applied once per clock edge
    task automatic model(bit fd, bit wr, logic [31:0] w, bit tk, bit sr);
        int thr = int'(w[23:16]);
        int dly = int'(w[31:24]);
        m_ioc = 0; m_dly = 0; dly_tag = "R7";
        if (sr) begin
            m_cnt = 1; m_tmr = 0; m_run = 0; cnt_tag = "R1"; tmr_tag = "R1";
            return;
        end
        if (fd) begin
            if (m_run && tk && m_tmr == 1) dly_tag = "R8";
            if (dly != 0) begin m_tmr = dly; m_run = 1; tmr_tag = "R4"; end
            else tmr_tag = "R5";
        end else if (m_run && tk) begin
            m_tmr = m_tmr - 1; tmr_tag = "R6";
            if (m_tmr == 0) begin m_run = 0; m_dly = 1; tmr_tag = "R7"; end
        end else tmr_tag = "R6";
        if (wr) begin m_cnt = thr; cnt_tag = "R2"; end
        else if (fd) begin
            m_cnt = (m_cnt + 255) % 256; cnt_tag = "R3";
            if (m_cnt == 0) begin m_cnt = thr; m_ioc = 1; end
        end else if (m_dly) begin m_cnt = thr; cnt_tag = "R7"; end
        else cnt_tag = "R9";
    endtask

    task automatic cyc(bit fd, bit wr, logic [31:0] w, bit tk, bit sr);
        frame_done = fd; ctrl_wr = wr; ctrl_word = w; tick = tk; soft_rst = sr;
        @(posedge clk);
        model(fd, wr, w, tk, sr);
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [31:0] mk(int dly, int thr);
        return {dly[7:0], thr[7:0], 16'h5a3c};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        compare_all();                          // R1 reset state
        rst_n = 1'b1;
        // R2: write threshold 3, delay 0
        cyc(0, 1, mk(0, 3), 0, 0);
        // R3, R5: three completions with zero delay, ticks ignored on a stopped timer
        cyc(1, 0, mk(0, 3), 1, 0);
        cyc(1, 0, mk(0, 3), 0, 0);
        cyc(1, 0, mk(0, 3), 1, 0);              // R3 ioc pulse here
        cyc(0, 0, mk(0, 3), 0, 0);
        // R4, R6, R7: arm delay 3, tick to expiry, then idle ticks
        cyc(1, 0, mk(3, 3), 0, 0);
        cyc(0, 0, mk(3, 3), 1, 0);
        cyc(0, 0, mk(3, 3), 0, 0);
        cyc(0, 0, mk(3, 3), 1, 0);
        cyc(0, 0, mk(3, 3), 1, 0);              // R7 expiry
        cyc(0, 0, mk(3, 3), 1, 0);
        // R8: completion on the cycle the timer would expire
        cyc(1, 0, mk(2, 5), 0, 0);
        cyc(0, 0, mk(2, 5), 1, 0);
        cyc(1, 0, mk(2, 5), 1, 0);
        // R5 on running timer: zero-delay completion on an expiry tick
        cyc(0, 0, mk(0, 5), 1, 0);
        cyc(1, 0, mk(0, 5), 1, 0);
        cyc(0, 0, mk(0, 5), 1, 0);
        // R2: write in the same cycle as a completion
        cyc(1, 1, mk(4, 1), 0, 0);
        cyc(1, 0, mk(4, 1), 0, 0);              // threshold 1: immediate ioc
        // R1: soft reset mid-run, overriding everything
        cyc(1, 1, mk(4, 1), 1, 1);
        cyc(0, 0, mk(4, 1), 1, 0);
        // R3 wrap: threshold 0 counts 256 completions
        cyc(0, 1, mk(0, 0), 0, 0);
        for (int i = 0; i < 257; i++) cyc(1, 0, mk(0, 0), 0, 0);
        // random mix of everything
        for (int i = 0; i < 4000; i++) begin
            int d = ($urandom % 4 == 0) ? 0 : 1 + $urandom % 5;
            int t = $urandom % 5;
            logic [31:0] w = ($urandom % 16 == 0) ? mk(d, t) : ctrl_word;
            cyc(($urandom % 6) == 0, ($urandom % 20) == 0, w,
                ($urandom % 3) != 0, ($urandom % 150) == 0);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule